// File: doc/BRIEF.md
# I2C Controller Transfer Sequencer

This block runs one whole I2C controller transaction, from the opening START to the closing STOP, in response to a single command. The command gives one of four sequence kinds, the target address, a flag that selects 7-bit or 10-bit addressing, and two byte counts, one for each of two buffers. The four kinds are write, read, write followed by read, and write followed by write. The block turns the command into a chain of bit-level operations: START, repeated START, STOP, send a byte and receive a byte. It issues these one at a time to a separate bit engine and waits for each to be acknowledged. The bit engine and the SCL timing are outside this block.

Bytes to be written are pulled from a valid/ready byte input, one byte per send operation. Bytes that are read leave on a data output with a single-cycle valid strobe. `busy` is high for the whole transaction. `done` pulses once when it ends, and `status` then holds the result code.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Kind 0 (write) issues START, the address byte with R/W = 0, one send for each of `cmd_len0` input bytes, then STOP. The status is 0 (done).
- R2: Kind 1 (read) issues START, the address byte with R/W = 1, `cmd_len0` receive operations whose bytes appear on `rd_data` with `rd_valid`, then STOP.
- R3: Kind 2 (write then read) issues START, the write address, the `cmd_len0` write bytes, a repeated START, the address with R/W = 1, `cmd_len1` receives, then STOP.
- R4: Kind 3 (write then write) sends the `cmd_len0` bytes and then the `cmd_len1` bytes after one START and one address byte, with no repeated START between the two groups, then STOP.
- R5: A write count of zero is legal. The block then sends only the address byte between START and STOP.
- R6: A receive count of zero (`cmd_len0` for kind 1, `cmd_len1` for kind 2) is a usage fault. No bus operation is issued, `done` pulses in the next cycle with status 5, and `busy` stays low.
- R7: In 7-bit mode the address byte is `cmd_addr[7:1]` followed by the R/W bit in bit 0.
- R8: In 10-bit mode two bytes are sent: {11110, `cmd_addr[10:9]`, R/W}, then `cmd_addr[7:0]`. After the repeated START of kind 2, only the first byte is sent again, with R/W = 1.
- R9: Each receive asks for an ACK (`be_rx_nack` = 0), except the last receive of a phase, which asks for a NACK (`be_rx_nack` = 1).
- R10: A NACK on an address byte or a data byte stops the sequence. The next operation is STOP, and the final status is 2.
- R11: An arbitration loss ends the transaction at once with no STOP and status 4. A bus error does the same with status 3.
- R12: While a transaction runs, `busy` = 1 and `status` = 1. Operation codes on `be_op` are 1 START, 2 repeated START, 3 STOP, 4 send, 5 receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_go | input | 1 | Start a command (taken when not busy) |
| cmd_kind | input | 2 | Sequence kind: 0 write, 1 read, 2 write-read, 3 write-write |
| cmd_addr | input | 11 | Address field (7-bit in [7:1], 10-bit in [10:9] and [7:0]) |
| cmd_ten | input | 1 | 10-bit addressing when 1 |
| cmd_len0 | input | LW | Byte count of buffer 0 |
| cmd_len1 | input | LW | Byte count of buffer 1 |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Block is waiting for a write byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| status | output | 3 | 0 done, 1 in progress, 2 NACK, 3 bus error, 4 arbitration lost, 5 usage fault |
| be_req | output | 1 | One-cycle operation request to the bit engine |
| be_op | output | 3 | Operation code |
| be_tx | output | 8 | Byte to send |
| be_rx_nack | output | 1 | Answer the received byte with NACK |
| be_ack | input | 1 | Bit engine finished the operation |
| be_nack | input | 1 | Sent byte was not acknowledged |
| be_arb_lost | input | 1 | Arbitration lost during the operation |
| be_bus_err | input | 1 | Misplaced START/STOP seen |
| be_rx | input | 8 | Received byte |

## Verification
The bench targets the switch points between phases. It checks the repeated START in write-read, which a wrong design would drop or would also insert in write-write. It checks that only the first 10-bit address byte is sent again after the repeated START, where a wrong design would send the low byte twice. It checks zero-length handling: a zero-length write must still send the address, and a zero-length read must be refused before any START, where a wrong design would hang or receive a byte. It also checks the error exits, where a wrong design would keep sending after a NACK, or send a STOP after losing arbitration. Finally it checks the ACK/NACK answer on the final received byte, which a wrong design would get backwards.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_kind,
  input  logic [10:0]   cmd_addr,
  input  logic          cmd_ten,
  input  logic [LW-1:0] cmd_len0,
  input  logic [LW-1:0] cmd_len1,
  input  logic [7:0]    wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic [2:0]    status,
  output logic          be_req,
  output logic [2:0]    be_op,
  output logic [7:0]    be_tx,
  output logic          be_rx_nack,
  input  logic          be_ack,
  input  logic          be_nack,
  input  logic          be_arb_lost,
  input  logic          be_bus_err,
  input  logic [7:0]    be_rx
);
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WRRD = 2'd2, K_WRWR = 2'd3;
  localparam logic [2:0] C_DONE = 3'd0, C_PROG = 3'd1, C_NACK = 3'd2,
                         C_BUS = 3'd3, C_ARB = 3'd4, C_USAGE = 3'd5;
  localparam logic [2:0] OP_NONE = 3'd0, OP_START = 3'd1, OP_RSTART = 3'd2,
                         OP_STOP = 3'd3, OP_SEND = 3'd4, OP_RECV = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR1, S_ADDR2, S_WR, S_RSTART, S_RD, S_STOP} st_t;

  st_t           st;
  logic          pend, rs_done, phase, ten;
  logic [1:0]    kind;
  logic [10:0]   addr;
  logic [LW-1:0] len1, cnt;
  logic [2:0]    err;

  wire rw      = (kind == K_RD) || rs_done;
  wire bad_cmd = (cmd_kind == K_RD && cmd_len0 == '0) || (cmd_kind == K_WRRD && cmd_len1 == '0);
  wire wr_zero = (st == S_WR) && (cnt == '0);

  assign busy       = (st != S_IDLE);
  assign wr_ready   = (st == S_WR) && !pend && (cnt != '0);
  assign be_req     = busy && !pend && (st != S_WR || (cnt != '0 && wr_valid));
  assign be_rx_nack = (st == S_RD) && (cnt == LW'(1));

  always_comb begin
    case (st)
      S_START:          be_op = OP_START;
      S_RSTART:         be_op = OP_RSTART;
      S_STOP:           be_op = OP_STOP;
      S_ADDR1, S_ADDR2,
      S_WR:             be_op = OP_SEND;
      S_RD:             be_op = OP_RECV;
      default:          be_op = OP_NONE;
    endcase
    if (st == S_ADDR1)      be_tx = ten ? {5'b11110, addr[10:9], rw} : {addr[7:1], rw};
    else if (st == S_ADDR2) be_tx = addr[7:0];
    else                    be_tx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; rs_done <= 1'b0; phase <= 1'b0; ten <= 1'b0;
      kind <= K_WR; addr <= '0; len1 <= '0; cnt <= '0; err <= C_DONE;
      status <= C_DONE; done <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (be_req) pend <= 1'b1;
      if (st == S_IDLE) begin
        if (cmd_go) begin
          if (bad_cmd) begin
            done <= 1'b1; status <= C_USAGE;
          end else begin
            st <= S_START; status <= C_PROG; err <= C_DONE;
            kind <= cmd_kind; addr <= cmd_addr; ten <= cmd_ten;
            cnt <= cmd_len0; len1 <= cmd_len1; rs_done <= 1'b0; phase <= 1'b0;
          end
        end
      end else if (wr_zero) begin
        if (!phase && kind == K_WRWR) begin
          phase <= 1'b1; cnt <= len1;
        end else if (!phase && kind == K_WRRD) st <= S_RSTART;
        else st <= S_STOP;
      end else if (be_ack) begin
        pend <= 1'b0;
        if (be_arb_lost || be_bus_err) begin
          st <= S_IDLE; done <= 1'b1; status <= be_arb_lost ? C_ARB : C_BUS;
        end else begin
          case (st)
            S_START:  st <= S_ADDR1;
            S_RSTART: begin st <= S_ADDR1; rs_done <= 1'b1; phase <= 1'b1; end
            S_ADDR1, S_ADDR2: begin
              if (be_nack) begin
                err <= C_NACK; st <= S_STOP;
              end else if (st == S_ADDR1 && ten && !rs_done) st <= S_ADDR2;
              else if (rw) begin
                st <= S_RD; cnt <= rs_done ? len1 : cnt;
              end else st <= S_WR;
            end
            S_WR: begin
              if (be_nack) begin
                err <= C_NACK; st <= S_STOP;
              end else cnt <= cnt - 1'b1;
            end
            S_RD: begin
              rd_data <= be_rx; rd_valid <= 1'b1; cnt <= cnt - 1'b1;
              if (cnt == LW'(1)) st <= S_STOP;
            end
            S_STOP: begin st <= S_IDLE; done <= 1'b1; status <= err; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R12
  AST_PROG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == C_PROG) else $error("busy without in-progress code"); // R12
  AST_USAGE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && bad_cmd) |=> (done && status == C_USAGE && !busy && !be_req)) else $error("usage fault"); // R6
  AST_ARB_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_ack && be_arb_lost) |=> (!busy && status == C_ARB && !be_req)) else $error("arb loss"); // R11
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_ack && be_nack && !be_arb_lost && !be_bus_err && be_op == OP_SEND) |=> (be_req && be_op == OP_STOP)) else $error("nack abort"); // R10
  AST_WRREADY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && be_op == OP_SEND)) else $error("write ready outside send"); // R1
endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  localparam int LW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_go = 0, cmd_ten = 0;
  logic [1:0] cmd_kind = 0;
  logic [10:0] cmd_addr = 0;
  logic [LW-1:0] cmd_len0 = 0, cmd_len1 = 0;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, busy, done;
  logic [2:0] status;
  logic be_req, be_rx_nack;
  logic [2:0] be_op;
  logic [7:0] be_tx;
  logic be_ack = 0, be_nack = 0, be_arb_lost = 0, be_bus_err = 0;
  logic [7:0] be_rx = 0;

  i2c_xfer_seq #(.LW(LW)) dut (.*);

  int checks = 0, errors = 0;
  int wcnt = 0, rn = 0, n = 0, dly = 0, cur = 0;
  int nack_at = -1, arb_at = -1, bus_at = -1;
  logic [2:0] lop [64];
  logic [7:0] ltx [64];
  logic       lnk [64];
  logic [7:0] rlog [64];
  logic [2:0] eop [64];
  logic [7:0] etx [64];
  int en = 0;

  assign wr_data = 8'h10 + wcnt[7:0];
  always @(posedge clk) begin
    if (wr_valid && wr_ready) wcnt <= wcnt + 1;
    if (rd_valid) begin rlog[rn] <= rd_data; rn <= rn + 1; end
  end

  always @(negedge clk) begin
    be_ack = 0; be_nack = 0; be_arb_lost = 0; be_bus_err = 0;
    if (dly != 0) begin
      dly = dly - 1;
      if (dly == 0) begin
        be_ack = 1; be_nack = (cur == nack_at); be_arb_lost = (cur == arb_at);
        be_bus_err = (cur == bus_at); be_rx = 8'hA0 + cur[7:0];
      end
    end
    if (be_req && n < 64) begin
      lop[n] = be_op; ltx[n] = be_tx; lnk[n] = be_rx_nack; cur = n; n = n + 1; dly = 2;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] tx);
    eop[en] = op; etx[en] = tx; en++;
  endtask

  task automatic run(input logic [1:0] k, input logic [10:0] a, input logic t,
                     input int l0, input int l1, output logic [2:0] st);
    int w;
    n = 0; en = 0; rn = 0;
    @(negedge clk);
    cmd_kind = k; cmd_addr = a; cmd_ten = t; cmd_len0 = l0[LW-1:0]; cmd_len1 = l1[LW-1:0]; cmd_go = 1;
    @(negedge clk);
    cmd_go = 0;
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    if (w >= 2000) chk("watchdog", 0, 1);
    st = status;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_ops(input string req);
    chk({req, " op count"}, n, en);
    for (int i = 0; i < en && i < n; i++) begin
      chk({req, " op"}, lop[i], eop[i]);
      if (eop[i] == 3'd4) chk({req, " tx byte"}, ltx[i], etx[i]);
    end
  endtask

  task automatic t_write;
    logic [2:0] st; int b;
    b = wcnt;
    @(negedge clk);
    cmd_kind = 0; cmd_addr = 11'h0A4; cmd_ten = 0; cmd_len0 = 2; cmd_go = 1;
    n = 0; en = 0;
    @(negedge clk); cmd_go = 0;
    chk("R12 busy", busy, 1); chk("R12 in-progress code", status, 1);
    while (!done) @(negedge clk);
    st = status;
    push(1, 0); push(4, 8'hA4); push(4, 8'h10 + b[7:0]); push(4, 8'h11 + b[7:0]); push(3, 0);
    cmp_ops("R1 R7"); chk("R1 status", st, 0); chk("R12 idle after", busy, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_read;
    logic [2:0] st;
    run(1, 11'h0A4, 0, 3, 0, st);
    push(1, 0); push(4, 8'hA5); push(5, 0); push(5, 0); push(5, 0); push(3, 0);
    cmp_ops("R2 R7"); chk("R2 status", st, 0);
    chk("R2 byte count", rn, 3);
    for (int i = 0; i < 3; i++) chk("R2 read data", rlog[i], 8'hA2 + i);
    chk("R9 ack first", lnk[2], 0); chk("R9 ack mid", lnk[3], 0); chk("R9 nack last", lnk[4], 1);
  endtask

  task automatic t_wrrd10;
    logic [2:0] st; int b;
    b = wcnt;
    run(2, 11'h45C, 1, 1, 2, st);
    push(1, 0); push(4, 8'hF4); push(4, 8'h5C); push(4, 8'h10 + b[7:0]); push(2, 0);
    push(4, 8'hF5); push(5, 0); push(5, 0); push(3, 0);
    cmp_ops("R3 R8"); chk("R3 status", st, 0);
    chk("R3 read data", rlog[0], 8'hA6); chk("R3 read data", rlog[1], 8'hA7);
    chk("R9 ack", lnk[6], 0); chk("R9 nack last", lnk[7], 1);
  endtask

  task automatic t_wrwr;
    logic [2:0] st; int b;
    b = wcnt;
    run(3, 11'h0A4, 0, 1, 2, st);
    push(1, 0); push(4, 8'hA4);
    for (int i = 0; i < 3; i++) push(4, 8'h10 + b[7:0] + i[7:0]);
    push(3, 0);
    cmp_ops("R4"); chk("R4 status", st, 0);
  endtask

  task automatic t_zero_wr;
    logic [2:0] st;
    run(0, 11'h0A4, 0, 0, 0, st);
    push(1, 0); push(4, 8'hA4); push(3, 0);
    cmp_ops("R5"); chk("R5 status", st, 0);
    run(3, 11'h0A4, 0, 0, 0, st);
    en = 0; push(1, 0); push(4, 8'hA4); push(3, 0);
    cmp_ops("R5 write-write"); chk("R5 status", st, 0);
  endtask

  task automatic t_usage;
    logic [2:0] st;
    run(1, 11'h0A4, 0, 0, 3, st);
    chk("R6 code read", st, 5); chk("R6 no ops", n, 0);
    run(2, 11'h0A4, 0, 2, 0, st);
    chk("R6 code write-read", st, 5); chk("R6 no ops", n, 0);
  endtask

  task automatic t_nack;
    logic [2:0] st; int b;
    b = wcnt; nack_at = 2;
    run(0, 11'h0A4, 0, 3, 0, st);
    nack_at = -1;
    push(1, 0); push(4, 8'hA4); push(4, 8'h10 + b[7:0]); push(3, 0);
    cmp_ops("R10 data nack"); chk("R10 code", st, 2);
    nack_at = 1;
    run(1, 11'h0A4, 0, 2, 0, st);
    nack_at = -1;
    en = 0; push(1, 0); push(4, 8'hA5); push(3, 0);
    cmp_ops("R10 address nack"); chk("R10 code", st, 2); chk("R10 no read", rn, 0);
  endtask

  task automatic t_arb;
    logic [2:0] st;
    arb_at = 1;
    run(0, 11'h0A4, 0, 2, 0, st);
    arb_at = -1;
    push(1, 0); push(4, 8'hA4);
    cmp_ops("R11 arb no stop"); chk("R11 arb code", st, 4);
    bus_at = 0;
    run(0, 11'h0A4, 0, 2, 0, st);
    bus_at = -1;
    chk("R11 bus err ops", n, 1); chk("R11 bus code", st, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", busy, 0); chk("R12 reset done", done, 0); chk("R12 reset req", be_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write; t_read; t_wrrd10; t_wrwr; t_zero_wr; t_usage; t_nack; t_arb;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule